// File: doc/BRIEF.md
# Per-Pixel Hit Timestamp Calibrator

This block sits between a 256-pixel time-to-digital converter array and the downstream hit processing. Each incoming hit carries the pixel address, the raw converter code of the first photon and a photon count. The raw code is turned into picoseconds using that pixel's own measured bin width. That pixel's own arrival-time offset is then removed, so all pixels share one time base. Per-pixel spread in bin width and offsets of several hundred picoseconds between pixels are corrected without any global conversion factor.

Both correction tables are filled through a simple write port from outside. Hits flow through a three-stage valid/ready pipeline: table lookup, rescale, offset subtraction. The address and count ride along untouched. A write is refused while any hit to the same pixel is offered or in flight. A hit therefore never sees a table entry change partway through.

Top module: `hit_time_calib`

## Requirements
- R1: After reset `out_valid_o` is 0, `in_ready_o` is 1, and every pixel's bin width entry is 240 (15 ps) and every offset entry is 0.
- R2: The output timestamp in ps is floor(code * width / 16) - offset, where width and offset are the entries for the hit's address.
- R3: The bin width table holds unsigned fixed-point values in 1/16 ps, 4 fractional bits. An accepted write with `cfg_sel_i` = 0 sets the entry at `cfg_addr_i` to `cfg_wdata_i`, and it is used for every hit accepted afterwards.
- R4: The offset table holds unsigned values in ps. An accepted write with `cfg_sel_i` = 1 sets the entry at `cfg_addr_i` to `cfg_wdata_i`, and it is used for every hit accepted afterwards.
- R5: When the offset exceeds the rescaled code, the timestamp is 0 and does not wrap.
- R6: The output address and count equal the input ones. With no output stall, a hit accepted in one cycle is presented three cycles later.
- R7: While `out_ready_i` is low, the presented hit and its fields hold steady. No hit is dropped, duplicated or reordered.
- R8: `cfg_ready_o` is low exactly when `cfg_addr_i` equals the address of an offered input hit or of any accepted hit not yet delivered. A write made while `cfg_ready_o` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input hit valid |
| in_ready_o | output | 1 | Input hit accepted when high with valid |
| in_addr_i | input | 8 | Pixel address |
| in_code_i | input | 10 | Raw converter code |
| in_cnt_i | input | 8 | Photon count |
| out_valid_o | output | 1 | Corrected hit valid |
| out_ready_i | input | 1 | Downstream ready |
| out_addr_o | output | 8 | Pixel address, passed through |
| out_cnt_o | output | 8 | Photon count, passed through |
| out_ts_o | output | 18 | Corrected timestamp in ps |
| cfg_we_i | input | 1 | Table write request |
| cfg_sel_i | input | 1 | Table select: 0 bin width, 1 offset |
| cfg_addr_i | input | 8 | Table entry address |
| cfg_wdata_i | input | 12 | Table entry value |
| cfg_ready_o | output | 1 | Write is accepted this cycle |

## Verification
The assertions check on every cycle that a stalled output holds, that accepted hits land in the first stage with their address and count, that table writes land in the addressed entry, that the subtraction either floors at zero or is exact, and that no write is accepted to the address being delivered. Only the bench scenarios can show end-to-end arithmetic against freshly written tables, ordering without loss under random backpressure, three-cycle latency, and that writes refused during a hazard leave later hits with the old values.

// File: rtl/calib_pkg.sv
package calib_pkg;
  typedef enum logic {
    SEL_WIDTH  = 1'b0,
    SEL_OFFSET = 1'b1
  } tbl_sel_e;
endpackage

// File: rtl/calib_table.sv
module calib_table #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 12,
  parameter int RST_VAL = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int NENT = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [NENT];

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem[g] <= DATA_W'(RST_VAL);
      else if (we_i && waddr_i == ADDR_W'(g))    mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];

  assert_entry_written_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/calib_scale.sv
module calib_scale #(
  parameter int CODE_W = 10,
  parameter int WID_W  = 12,
  parameter int FRAC   = 4,
  localparam int PROD_W = CODE_W + WID_W,
  localparam int OUT_W  = PROD_W - FRAC
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [WID_W-1:0]  width_i,
  output logic [OUT_W-1:0]  scaled_o
);
  logic [PROD_W-1:0] prod;

  assign prod     = PROD_W'(code_i) * PROD_W'(width_i);
  assign scaled_o = OUT_W'(prod >> FRAC);
endmodule

// File: rtl/calib_sat_sub.sv
module calib_sat_sub #(
  parameter int A_W = 18,
  parameter int B_W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           chk_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [A_W-1:0] res_o
);
  logic [A_W-1:0] b_ext;

  assign b_ext = A_W'(b_i);
  assign res_o = (a_i >= b_ext) ? a_i - b_ext : '0;

  // floor at zero, otherwise exact
  assert_sat_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_i |-> (res_o == '0) || ({1'b0, res_o} + {1'b0, b_ext} == {1'b0, a_i}));
endmodule

// File: rtl/hit_time_calib.sv
module hit_time_calib
  import calib_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CODE_W  = 10,
  parameter int CNT_W   = 8,
  parameter int TBL_W   = 12,
  parameter int FRAC    = 4,
  parameter int WID_RST = 240,
  localparam int TS_W   = CODE_W + TBL_W - FRAC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [CODE_W-1:0] in_code_i,
  input  logic [CNT_W-1:0]  in_cnt_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [CNT_W-1:0]  out_cnt_o,
  output logic [TS_W-1:0]   out_ts_o,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [TBL_W-1:0]  cfg_wdata_i,
  output logic              cfg_ready_o
);
  logic adv;
  logic hazard;
  logic wid_we, off_we;
  logic [TBL_W-1:0] wid_rd, off_rd;

  // stage 1: lookup
  logic              s1_v;
  logic [ADDR_W-1:0] s1_addr;
  logic [CNT_W-1:0]  s1_cnt;
  logic [CODE_W-1:0] s1_code;
  logic [TBL_W-1:0]  s1_wid, s1_off;
  // stage 2: rescale
  logic              s2_v;
  logic [ADDR_W-1:0] s2_addr;
  logic [CNT_W-1:0]  s2_cnt;
  logic [TS_W-1:0]   s2_scaled;
  logic [TBL_W-1:0]  s2_off;
  // stage 3: subtract
  logic              s3_v;
  logic [ADDR_W-1:0] s3_addr;
  logic [CNT_W-1:0]  s3_cnt;
  logic [TS_W-1:0]   s3_ts;

  logic [TS_W-1:0] scaled_c, ts_c;

  assign adv        = !s3_v || out_ready_i;
  assign in_ready_o = adv;

  // hit to this pixel offered or in flight: refuse write
  assign hazard = (in_valid_i && in_addr_i == cfg_addr_i) ||
                  (s1_v && s1_addr == cfg_addr_i) ||
                  (s2_v && s2_addr == cfg_addr_i) ||
                  (s3_v && s3_addr == cfg_addr_i);
  assign cfg_ready_o = !hazard;
  assign wid_we = cfg_we_i && cfg_ready_o && tbl_sel_e'(cfg_sel_i) == SEL_WIDTH;
  assign off_we = cfg_we_i && cfg_ready_o && tbl_sel_e'(cfg_sel_i) == SEL_OFFSET;

  calib_table #(.ADDR_W(ADDR_W), .DATA_W(TBL_W), .RST_VAL(WID_RST)) i_wid_tbl (
    .clk_i, .rst_ni, .we_i(wid_we), .waddr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .raddr_i(in_addr_i), .rdata_o(wid_rd)
  );

  calib_table #(.ADDR_W(ADDR_W), .DATA_W(TBL_W), .RST_VAL(0)) i_off_tbl (
    .clk_i, .rst_ni, .we_i(off_we), .waddr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .raddr_i(in_addr_i), .rdata_o(off_rd)
  );

  calib_scale #(.CODE_W(CODE_W), .WID_W(TBL_W), .FRAC(FRAC)) i_scale (
    .code_i(s1_code), .width_i(s1_wid), .scaled_o(scaled_c)
  );

  calib_sat_sub #(.A_W(TS_W), .B_W(TBL_W)) i_sub (
    .clk_i, .rst_ni, .chk_i(s2_v), .a_i(s2_scaled), .b_i(s2_off), .res_o(ts_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v <= 1'b0; s1_addr <= '0; s1_cnt <= '0; s1_code <= '0; s1_wid <= '0; s1_off <= '0;
      s2_v <= 1'b0; s2_addr <= '0; s2_cnt <= '0; s2_scaled <= '0; s2_off <= '0;
      s3_v <= 1'b0; s3_addr <= '0; s3_cnt <= '0; s3_ts <= '0;
    end else if (adv) begin
      s1_v <= in_valid_i;
      if (in_valid_i) begin
        s1_addr <= in_addr_i;
        s1_cnt  <= in_cnt_i;
        s1_code <= in_code_i;
        s1_wid  <= wid_rd;
        s1_off  <= off_rd;
      end
      s2_v <= s1_v;
      if (s1_v) begin
        s2_addr   <= s1_addr;
        s2_cnt    <= s1_cnt;
        s2_scaled <= scaled_c;
        s2_off    <= s1_off;
      end
      s3_v <= s2_v;
      if (s2_v) begin
        s3_addr <= s2_addr;
        s3_cnt  <= s2_cnt;
        s3_ts   <= ts_c;
      end
    end
  end

  assign out_valid_o = s3_v;
  assign out_addr_o  = s3_addr;
  assign out_cnt_o   = s3_cnt;
  assign out_ts_o    = s3_ts;

  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_ts_o) &&
                                    $stable(out_addr_o) && $stable(out_cnt_o));

  assert_capture_fields_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> s1_v && s1_addr == $past(in_addr_i) &&
                                 s1_cnt == $past(in_cnt_i) && s1_code == $past(in_code_i));

  assert_no_live_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_ready_o |-> !(out_valid_o && out_addr_o == cfg_addr_i));
endmodule

// File: tb/test_hit_time_calib.sv
`timescale 1ns/1ps
module test_hit_time_calib;
  localparam int ADDR_W = 8;
  localparam int CODE_W = 10;
  localparam int CNT_W  = 8;
  localparam int TBL_W  = 12;
  localparam int TS_W   = 18;
  localparam int NPIX   = 1 << ADDR_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_ni = 1'b0;
  logic              in_valid_i = 1'b0, in_ready_o;
  logic [ADDR_W-1:0] in_addr_i = '0;
  logic [CODE_W-1:0] in_code_i = '0;
  logic [CNT_W-1:0]  in_cnt_i = '0;
  logic              out_valid_o, out_ready_i = 1'b1;
  logic [ADDR_W-1:0] out_addr_o;
  logic [CNT_W-1:0]  out_cnt_o;
  logic [TS_W-1:0]   out_ts_o;
  logic              cfg_we_i = 1'b0, cfg_sel_i = 1'b0, cfg_ready_o;
  logic [ADDR_W-1:0] cfg_addr_i = '0;
  logic [TBL_W-1:0]  cfg_wdata_i = '0;

  hit_time_calib i_hit_time_calib (
    .clk_i(clk), .rst_ni, .in_valid_i, .in_ready_o, .in_addr_i, .in_code_i, .in_cnt_i,
    .out_valid_o, .out_ready_i, .out_addr_o, .out_cnt_o, .out_ts_o,
    .cfg_we_i, .cfg_sel_i, .cfg_addr_i, .cfg_wdata_i, .cfg_ready_o
  );

  typedef struct {int addr; int cnt; int ts; int cyc;} exp_t;
  exp_t q[$];
  int wid_m[NPIX];
  int off_m[NPIX];
  int n_run = 0, n_fail = 0, cyc = 0, last_stall = -1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model_ts(int a, int code);
    int v;
    v = ((code * wid_m[a]) >>> 4) - off_m[a];
    return (v < 0) ? 0 : v;
  endfunction

  task automatic step(bit iv, int ia, int ic, int icnt, bit ordy,
                      bit we, bit sel, int wa, int wd, output bit acc);
    exp_t e;
    bit exp_rdy;
    @(negedge clk);
    in_valid_i = iv; in_addr_i = ADDR_W'(ia); in_code_i = CODE_W'(ic); in_cnt_i = CNT_W'(icnt);
    out_ready_i = ordy;
    cfg_we_i = we; cfg_sel_i = sel; cfg_addr_i = ADDR_W'(wa); cfg_wdata_i = TBL_W'(wd);
    #1;
    if (we) begin
      exp_rdy = 1'b1;
      if (iv && ia == wa) exp_rdy = 1'b0;
      foreach (q[k]) if (q[k].addr == wa) exp_rdy = 1'b0;
      chk(cfg_ready_o == exp_rdy, "R8", "cfg_ready_o", int'(cfg_ready_o), int'(exp_rdy));
    end
    if (out_valid_o && !ordy) last_stall = cyc;
    if (out_valid_o && ordy) begin
      if (q.size() == 0) chk(1'b0, "R7", "output with nothing pending", 1, 0);
      else begin
        e = q.pop_front();
        chk(int'(out_ts_o) == e.ts, (e.ts == 0) ? "R5" : "R2", "out_ts_o", int'(out_ts_o), e.ts);
        chk(int'(out_addr_o) == e.addr, "R6", "out_addr_o", int'(out_addr_o), e.addr);
        chk(int'(out_cnt_o) == e.cnt, "R6", "out_cnt_o", int'(out_cnt_o), e.cnt);
        if (last_stall < e.cyc) chk(cyc == e.cyc + 3, "R6", "latency", cyc - e.cyc, 3);
      end
    end
    acc = iv && in_ready_o;
    if (acc) begin
      e.addr = ia; e.cnt = icnt; e.ts = model_ts(ia, ic); e.cyc = cyc;
      q.push_back(e);
    end
    if (we && cfg_ready_o) begin
      if (sel) off_m[wa] = wd; else wid_m[wa] = wd;
    end
    cyc++;
  endtask

  task automatic idle(int n, bit ordy);
    bit acc;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, ordy, 0, 0, 0, 0, acc);
  endtask

  task automatic wr(bit sel, int a, int d);
    bit acc;
    step(0, 0, 0, 0, 1, 1, sel, a, d, acc);
  endtask

  task automatic send(int a, int code, int cnt);
    bit acc = 0;
    while (!acc) step(1, a, code, cnt, 1, 0, 0, 0, 0, acc);
  endtask

  task automatic send_rand(int a, int code, int cnt);
    bit acc = 0;
    while (!acc)
      step(1, a, code, cnt, ($urandom % 4) != 0, ($urandom % 4) == 0, $urandom % 2,
           $urandom % 16, $urandom % 4096, acc);
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit acc;
    for (int i = 0; i < NPIX; i++) begin wid_m[i] = 240; off_m[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1: idle outputs after reset
    chk(out_valid_o == 1'b0, "R1", "out_valid_o", int'(out_valid_o), 0);
    chk(in_ready_o == 1'b1, "R1", "in_ready_o", int'(in_ready_o), 1);
    chk(cfg_ready_o == 1'b1, "R1", "cfg_ready_o", int'(cfg_ready_o), 1);
    // R1 R2: reset tables give 15 ps bins, no offset -> 100 * 15 = 1500
    send(3, 100, 9);
    send(200, 1023, 255);
    send(0, 0, 1);
    idle(6, 1);
    // R3: width 20 ps at pixel 20 -> 50 * 20 = 1000
    wr(0, 20, 320);
    // R4: 300 ps offset at pixel 21 -> 1500 - 300 = 1200
    wr(1, 21, 300);
    send(20, 50, 4);
    send(21, 100, 5);
    idle(6, 1);
    // R5: floor at zero around the boundary, 1 ps bins, 1000 ps offset
    wr(0, 5, 16);
    wr(1, 5, 1000);
    send(5, 999, 1);
    send(5, 1000, 2);
    send(5, 1001, 3);
    idle(6, 1);
    // R8: hit to pixel 7 held by backpressure blocks writes to 7 only
    step(1, 7, 200, 7, 0, 0, 0, 0, 0, acc);
    idle(4, 0);
    step(0, 0, 0, 0, 0, 1, 0, 7, 16, acc);
    step(0, 0, 0, 0, 0, 1, 1, 7, 999, acc);
    step(0, 0, 0, 0, 0, 1, 1, 8, 10, acc);
    idle(6, 1);
    send(7, 200, 8);   // still 15 ps bins, no offset -> 3000
    send(8, 200, 8);   // offset 10 -> 2990
    idle(6, 1);
    // R7 R8 R2: random stream with backpressure and concurrent writes
    for (int i = 0; i < 400; i++) begin
      int c;
      c = $urandom % 1024;
      if (i % 37 == 0) c = 1023;
      if (i % 41 == 0) c = 0;
      send_rand($urandom % 16, c, $urandom % 256);
    end
    idle(10, 1);
    // R7: everything delivered exactly once
    chk(q.size() == 0, "R7", "undelivered hits", q.size(), 0);
    chk(out_valid_o == 1'b0, "R7", "out_valid_o after drain", int'(out_valid_o), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule